// File: doc/BRIEF.md
# Dual-Select Byte-Lane Static RAM Model

This block is a clocked, synthesizable stand-in for an asynchronous static RAM with two byte lanes. It is a target for memory-controller verification. It gives a controller a device whose mode decode, lane gating and write timing behave like the real part. It does not model analog timing.

Every control and data input is sampled on the rising clock edge. The registered outputs show the result of that sample one edge later:
- the read data,
- a drive flag for each lane,
- the standby flag.

The tri-state data bus is split into three parts: an input path, an output path, and the two per-lane drive flags.

The device has two chip selects of opposite polarity. One is active low and one is active high. A write lasts for as long as every write condition holds together. The data is committed on the sample where that window closes.

A strap input picks the organisation of the same storage:
- Word mode: 16 bits wide.
- Byte mode: 8 bits wide. In byte mode the top data input bit becomes an extra address bit. That bit selects the half of the stored word that is accessed.

Top module: `dual_select_sram`

## Requirements
- R1: The device is selected only while `selLowN` is 0 and `selHigh` is 1. On any other sample, the next output shows `standby`=1 and both drive flags 0.
- R2: In word mode (`wideMode`=1), a sample with `hiLaneN`=1 and `loLaneN`=1 counts as deselected, whatever the selects are. The next output shows `standby`=1 with no lane driven.
- R3: In word mode, a write stores `dataIn[7:0]` into bits 7:0 of the word when `loLaneN` is 0. It stores `dataIn[15:8]` into bits 15:8 when `hiLaneN` is 0. A lane whose enable is 1 keeps its old contents.
- R4: A read (selected, `wrN`=1, `oeN`=0) in word mode raises `driveLo` for `loLaneN`=0 and `driveHi` for `hiLaneN`=0. The matching byte of the stored word appears on that lane of `dataOut`. A lane that is not driven reads as 0 on `dataOut`.
- R5: A selected sample with `wrN`=1 and `oeN`=1 gives `standby`=0 with both drive flags 0.
- R6: While a write window is open (selected with `wrN`=0), neither lane is driven, even with `oeN`=0.
- R7: The write window is open on every sample where `wrN` is 0 and the device is selected. The window ends when any of these happens: `wrN` rises, either select goes inactive, or the byte enables both go to 1. The store happens on the first sample after the window ends. It takes `dataIn` from that closing sample, and the address and lane set from the last open sample.
- R8: In byte mode (`wideMode`=0), `dataIn[15]` acts as an extra address bit: 0 picks bits 7:0 of the word and 1 picks bits 15:8. Write data comes from `dataIn[7:0]` and read data appears on `dataOut[7:0]` with `driveLo`=1. `driveHi` stays 0, and `hiLaneN`/`loLaneN` have no effect.
- R9: A read sampled on the same edge that closes a write to the same address returns the newly written data.
- R10: While `rstN` is 0 the outputs hold `standby`=1, both drive flags 0 and `dataOut`=0, and any open write window is dropped without a store. Outputs always reflect the inputs of the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selLowN | input | 1 | Chip select, active low |
| selHigh | input | 1 | Chip select, active high |
| wrN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| hiLaneN | input | 1 | Upper byte lane enable, active low (word mode) |
| loLaneN | input | 1 | Lower byte lane enable, active low (word mode) |
| wideMode | input | 1 | Organisation strap: 1 word mode, 0 byte mode |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| dataIn | input | 16 | Bus input path; bit 15 is the extra address bit in byte mode |
| dataOut | output | 16 | Bus output path, zero on lanes not driven |
| driveLo | output | 1 | Lower lane is driven |
| driveHi | output | 1 | Upper lane is driven |
| standby | output | 1 | Device deselected |

## Verification
The hardest situation to reach is a write window that closes on the same edge that starts a read of the freshly written word. Reaching it requires `wrN` to rise while `oeN` is already 0, with the selects and lane enables held. The stimulus builds exactly that sequence. It also closes other windows through each of the other controls, with the data changed only on the closing sample, so a store that used the wrong sample would be visible. A reference model runs every cycle, and a random phase mixes word and byte mode on a small set of addresses that were written first.

// File: rtl/dual_select_sram_pkg.sv
package dual_select_sram_pkg;

  // Strobes from control to datapath, valid for the current sample
  typedef struct packed {
    logic       commit;       // write window closed on this sample
    logic [1:0] commitMask;   // lanes to store, bit1 = upper
    logic       commitNarrow; // byte-mode write: low data byte goes to the chosen lane
    logic       readEn;       // read decoded on this sample
    logic [1:0] readMask;     // word-mode lanes requested
    logic       readNarrow;   // byte-mode read
    logic       readHiSel;    // byte-mode half select
    logic       idle;         // device deselected
  } strobe_t;

endpackage

// File: rtl/dual_select_sram_ctrl.sv
module dual_select_sram_ctrl
  import dual_select_sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          selLowN,
  input  logic          selHigh,
  input  logic          wrN,
  input  logic          oeN,
  input  logic          hiLaneN,
  input  logic          loLaneN,
  input  logic          wideMode,
  input  logic          topBit,
  input  logic [AW-1:0] addr,
  output strobe_t       stb,
  output logic [AW-1:0] commitAddr
);

  logic       selected;
  logic       winNow;
  logic [1:0] curMask;

  logic       winOpen;
  logic [1:0] winMask;
  logic       winNarrow;

  always_comb begin
    selected = !selLowN && selHigh && (!wideMode || !(hiLaneN && loLaneN));
    winNow   = selected && !wrN;
    curMask  = wideMode ? {!hiLaneN, !loLaneN} : {topBit, !topBit};
  end

  always_comb begin
    stb.commit       = winOpen && !winNow;
    stb.commitMask   = winMask;
    stb.commitNarrow = winNarrow;
    stb.readEn       = selected && wrN && !oeN;
    stb.readMask     = curMask;
    stb.readNarrow   = !wideMode;
    stb.readHiSel    = topBit;
    stb.idle         = !selected;
  end

  // Window tracker: remembers where and which lanes of the last open sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winOpen    <= 1'b0;
      winMask    <= '0;
      winNarrow  <= 1'b0;
      commitAddr <= '0;
    end else begin
      winOpen <= winNow;
      if (winNow) begin
        winMask    <= curMask;
        winNarrow  <= !wideMode;
        commitAddr <= addr;
      end
    end
  end

endmodule

// File: rtl/dual_select_sram_datapath.sv
module dual_select_sram_datapath
  import dual_select_sram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int LANE_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LANES = 2,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [AW-1:0]     commitAddr,
  input  logic [AW-1:0]     readAddr,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] dataOut,
  output logic              driveLo,
  output logic              driveHi,
  output logic              standby
);

  logic [WORD_W-1:0] wrWord;
  logic [WORD_W-1:0] rdWord;
  logic              sameAddr;

  assign wrWord   = stb.commitNarrow ? {LANES{dataIn[LANE_W-1:0]}} : dataIn;
  assign sameAddr = stb.commit && (commitAddr == readAddr);

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic              laneWr;

    assign laneWr = stb.commit && stb.commitMask[ln];

    always_ff @(posedge clk) begin
      if (laneWr) laneMem[commitAddr] <= wrWord[ln*LANE_W +: LANE_W];
    end

    // Bypass so a read on the closing sample sees the stored data
    assign rdWord[ln*LANE_W +: LANE_W] = (laneWr && sameAddr)
                                         ? wrWord[ln*LANE_W +: LANE_W]
                                         : laneMem[readAddr];
  end

  logic [LANE_W-1:0] loByte;
  logic              loNext;
  logic              hiNext;

  always_comb begin
    loByte = (stb.readNarrow && stb.readHiSel) ? rdWord[WORD_W-1 -: LANE_W]
                                               : rdWord[LANE_W-1:0];
    loNext = stb.readEn && (stb.readNarrow || stb.readMask[0]);
    hiNext = stb.readEn && !stb.readNarrow && stb.readMask[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      driveLo <= 1'b0;
      driveHi <= 1'b0;
      standby <= 1'b1;
    end else begin
      dataOut <= {hiNext ? rdWord[WORD_W-1 -: LANE_W] : {LANE_W{1'b0}},
                  loNext ? loByte : {LANE_W{1'b0}}};
      driveLo <= loNext;
      driveHi <= hiNext;
      standby <= stb.idle;
    end
  end

endmodule

// File: rtl/dual_select_sram.sv
module dual_select_sram
  import dual_select_sram_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          selLowN,
  input  logic          selHigh,
  input  logic          wrN,
  input  logic          oeN,
  input  logic          hiLaneN,
  input  logic          loLaneN,
  input  logic          wideMode,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   dataIn,
  output logic [15:0]   dataOut,
  output logic          driveLo,
  output logic          driveHi,
  output logic          standby
);

  strobe_t       stb;
  logic [AW-1:0] commitAddr;

  dual_select_sram_ctrl #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .selLowN    (selLowN),
    .selHigh    (selHigh),
    .wrN        (wrN),
    .oeN        (oeN),
    .hiLaneN    (hiLaneN),
    .loLaneN    (loLaneN),
    .wideMode   (wideMode),
    .topBit     (dataIn[15]),
    .addr       (addr),
    .stb        (stb),
    .commitAddr (commitAddr)
  );

  dual_select_sram_datapath #(.DEPTH(DEPTH), .LANE_W(8)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .commitAddr (commitAddr),
    .readAddr   (addr),
    .dataIn     (dataIn),
    .dataOut    (dataOut),
    .driveLo    (driveLo),
    .driveHi    (driveHi),
    .standby    (standby)
  );

endmodule

// File: rtl/dual_select_sram_checker.sv
module dual_select_sram_checker (
  input logic clk,
  input logic rstN,
  input logic selLowN,
  input logic selHigh,
  input logic wrN,
  input logic oeN,
  input logic hiLaneN,
  input logic loLaneN,
  input logic wideMode,
  input logic driveLo,
  input logic driveHi,
  input logic standby
);

  logic chosen;
  assign chosen = !selLowN && selHigh && (!wideMode || !(hiLaneN && loLaneN));

  // R1
  deselect_standby_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selLowN || !selHigh) |=> (standby && !driveLo && !driveHi));

  // R2
  lanes_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wideMode && hiLaneN && loLaneN) |=> (standby && !driveLo && !driveHi));

  // R4
  word_read_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chosen && wideMode && wrN && !oeN) |=>
      (driveLo == !$past(loLaneN) && driveHi == !$past(hiLaneN)));

  // R5
  out_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chosen && wrN && oeN) |=> (!standby && !driveLo && !driveHi));

  // R6
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chosen && !wrN) |=> (!driveLo && !driveHi && !standby));

  // R8
  narrow_hi_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wideMode) |=> !driveHi);

endmodule

bind dual_select_sram dual_select_sram_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .selLowN  (selLowN),
  .selHigh  (selHigh),
  .wrN      (wrN),
  .oeN      (oeN),
  .hiLaneN  (hiLaneN),
  .loLaneN  (loLaneN),
  .wideMode (wideMode),
  .driveLo  (driveLo),
  .driveHi  (driveHi),
  .standby  (standby)
);

// File: tb/test_dual_select_sram.sv
module test_dual_select_sram;

  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          selLowN = 1'b1, selHigh = 1'b0, wrN = 1'b1, oeN = 1'b1;
  logic          hiLaneN = 1'b1, loLaneN = 1'b1, wideMode = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   dataIn = '0;
  logic [15:0]   dataOut;
  logic          driveLo, driveHi, standby;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  dual_select_sram #(.DEPTH(DEPTH)) i_dual_select_sram (
    .clk(clk), .rstN(rstN), .selLowN(selLowN), .selHigh(selHigh),
    .wrN(wrN), .oeN(oeN), .hiLaneN(hiLaneN), .loLaneN(loLaneN),
    .wideMode(wideMode), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .driveLo(driveLo), .driveHi(driveHi), .standby(standby)
  );

  // Reference model state
  logic [15:0] mdl [DEPTH];
  bit          mOpen = 0;
  int          mAddr = 0;
  bit [1:0]    mMask = 0;
  bit          mNarrow = 0;
  logic [15:0] expData = '0;
  bit          expLo = 0, expHi = 0, expSb = 1;
  string       pendTag = "R10 reset";

  task automatic checkNow();
    total++;
    if (dataOut !== expData || driveLo !== expLo || driveHi !== expHi || standby !== expSb) begin
      bad++;
      $display("FAIL %s: got data=%h lo=%0d hi=%0d sb=%0d, expected data=%h lo=%0d hi=%0d sb=%0d",
               pendTag, dataOut, driveLo, driveHi, standby, expData, expLo, expHi, expSb);
    end
  endtask

  // One sample: check previous result, drive new inputs, predict next result
  task automatic step(string tag, bit rst, bit s1n, bit s2, bit w, bit o,
                      bit hn, bit lnN, bit wide, int a, logic [15:0] d);
    bit sel, win, rd, a20;
    logic [15:0] word, cur;
    @(negedge clk);
    checkNow();
    rstN = !rst; selLowN = s1n; selHigh = s2; wrN = w; oeN = o;
    hiLaneN = hn; loLaneN = lnN; wideMode = wide; addr = AW'(a); dataIn = d;
    pendTag = tag;
    if (rst) begin
      mOpen = 0; expData = '0; expLo = 0; expHi = 0; expSb = 1;
      return;
    end
    sel = !s1n && s2 && (!wide || !(hn && lnN));
    win = sel && !w;
    rd  = sel && w && !o;
    a20 = d[15];
    if (mOpen && !win) begin
      word = mNarrow ? {d[7:0], d[7:0]} : d;
      cur = mdl[mAddr];
      if (mMask[0]) cur[7:0] = word[7:0];
      if (mMask[1]) cur[15:8] = word[15:8];
      mdl[mAddr] = cur;
    end
    if (win) begin
      mOpen = 1; mAddr = a; mNarrow = !wide;
      mMask = wide ? {!hn, !lnN} : (a20 ? 2'b10 : 2'b01);
    end else mOpen = 0;
    expSb = !sel; expLo = 0; expHi = 0; expData = '0;
    if (rd) begin
      if (wide) begin
        expLo = !lnN; expHi = !hn;
        if (expLo) expData[7:0] = mdl[a][7:0];
        if (expHi) expData[15:8] = mdl[a][15:8];
      end else begin
        expLo = 1;
        expData[7:0] = a20 ? mdl[a][15:8] : mdl[a][7:0];
      end
    end
  endtask

  // shorthand: selected word-mode sample
  task automatic wd(string tag, bit w, bit o, bit hn, bit lnN, int a, logic [15:0] d);
    step(tag, 0, 0, 1, w, o, hn, lnN, 1, a, d);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 1, 0, 1, 0, 0, 0, 1, 0, 16'h0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = 'x;
    // R10: outputs held during reset, even with a read set up
    step("R10 reset", 1, 0, 1, 1, 0, 0, 0, 1, 0, 16'h0);
    step("R10 reset", 1, 0, 1, 1, 0, 0, 0, 1, 0, 16'h0);
    idle("R1 deselect select-low inactive");
    // R1: each select alone inactive, read otherwise requested
    step("R1 selHigh low", 0, 0, 0, 1, 0, 0, 0, 1, 0, 16'h0);
    step("R1 selLowN high", 0, 1, 1, 1, 0, 0, 0, 1, 0, 16'h0);
    // R7/R3: open window with one data value, close by wrN with another
    wd("R6 window open", 0, 1, 0, 0, 5, 16'h1111);
    wd("R7 close by wrN", 1, 1, 0, 0, 5, 16'hA5C3);
    wd("R4 read both lanes", 1, 0, 0, 0, 5, 16'h0);
    // R3: upper lane only, closed by byte enables both going inactive
    wd("R6 upper-only window", 0, 1, 0, 1, 5, 16'h7E00);
    wd("R7 R2 close by lane enables", 0, 1, 1, 1, 5, 16'h7E99);
    wd("R3 read after upper write", 1, 0, 0, 0, 5, 16'h0);
    wd("R4 low lane only", 1, 0, 1, 0, 5, 16'h0);
    wd("R4 high lane only", 1, 0, 0, 1, 5, 16'h0);
    // R6: write with OE low, closed by selHigh falling
    wd("R6 no drive with oeN low", 0, 0, 0, 0, 7, 16'h2222);
    step("R7 close by selHigh", 0, 0, 0, 0, 0, 0, 0, 1, 7, 16'h3C4D);
    wd("R3 read addr 7", 1, 0, 0, 0, 7, 16'h0);
    // R7: lower-lane write closed by selLowN rising
    wd("R6 low-lane window", 0, 1, 1, 0, 7, 16'hFFEE);
    step("R7 close by selLowN", 0, 1, 1, 0, 1, 1, 0, 1, 7, 16'hFF81);
    wd("R3 low lane kept high", 1, 0, 0, 0, 7, 16'h0);
    // R9: closing edge is also a read of the same word
    wd("R6 window before read", 0, 0, 0, 0, 9, 16'h0BAD);
    wd("R9 read on closing edge", 1, 0, 0, 0, 9, 16'h600D);
    wd("R9 read again", 1, 0, 0, 0, 9, 16'h0);
    // R2 and R5
    wd("R2 both lane enables off", 1, 0, 1, 1, 9, 16'h0);
    wd("R5 outputs disabled", 1, 1, 0, 0, 9, 16'h0);
    // R8: byte mode, lane enables deliberately inactive (ignored)
    step("R8 byte write upper half", 0, 0, 1, 0, 1, 1, 1, 0, 3, 16'h8000);
    step("R8 byte close", 0, 0, 1, 1, 1, 1, 1, 0, 3, 16'h803C);
    step("R8 byte write lower half", 0, 0, 1, 0, 1, 1, 1, 0, 3, 16'h0000);
    step("R8 byte close lower", 0, 0, 1, 1, 1, 1, 1, 0, 3, 16'h00D7);
    step("R8 byte read upper half", 0, 0, 1, 1, 0, 1, 1, 0, 3, 16'h8000);
    step("R8 byte read lower half", 0, 0, 1, 1, 0, 0, 1, 0, 3, 16'h0000);
    wd("R8 word view of byte writes", 1, 0, 0, 0, 3, 16'h0);
    // R10: reset drops an open window without a store
    wd("R6 window before reset", 0, 1, 0, 0, 9, 16'hDEAD);
    step("R10 reset mid-window", 1, 0, 1, 1, 1, 0, 0, 1, 9, 16'hDEAD);
    wd("R10 word kept after reset", 1, 0, 0, 0, 9, 16'h0);
    // initialise a small set, then random mixed traffic
    for (int i = 0; i < 8; i++) begin
      wd("R3 init", 0, 1, 0, 0, i, 16'(i * 16'h1357));
      wd("R7 init close", 1, 1, 0, 0, i, 16'(i * 16'h1357 + 16'h0101));
    end
    for (int i = 0; i < 400; i++) begin
      step("R1 R4 R7 R8 random", 0, ($urandom % 5) == 0, ($urandom % 5) != 0,
           $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
           ($urandom % 3) != 0, $urandom % 8, 16'($urandom));
    end
    idle("R1 final");
    @(negedge clk);
    checkNow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    bad++;
    total++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule